// File: doc/BRIEF.md
# Edge-Triggered Time Base Capture Unit

This block records which phase a slow time base is in at the moment an external pin changes state. A free-running divider chain supplies a small group of low-frequency taps (256 Hz, 128 Hz, 64 Hz and 32 Hz). Each of two channels watches one pin. When that pin makes its active transition, the channel copies the tap group into its own capture register. Software can then read the register to timestamp the event coarsely within one 32 Hz period.

The active transition follows the pin's bias setting. A pin biased by a pull-up idles high, so its channel captures when the pin falls. A pin biased by a pull-down idles low, so its channel captures when the pin rises. Each pin first passes through a two-flop synchronizer. The synchronized level is then judged only on cycles where the time base's sampling strobe is high. A capture sets a per-channel done flag, which software clears by writing 1 to it. An interrupt request is raised while any enabled channel has its flag set.

Software reaches the block through a plain register bus. Writes are single-cycle strobes, and reads are combinational from the address. The bus has no valid/ready handshake and no back-pressure: every write is accepted in the cycle it is presented, and read data is valid in the same cycle as the address.

Top module: `tbcap_unit`

## Requirements
- R1: After reset the control register, both capture registers and `irq` are all zero.
- R2: With bias bit = 1 (pull-up), a channel captures on a high-to-low change of its synchronized pin. A low-to-high change on that pin does not capture.
- R3: With bias bit = 0 (pull-down), a channel captures on a low-to-high change of its synchronized pin. A high-to-low change on that pin does not capture.
- R4: A capture stores `tb_taps`, with bit 3 = 256 Hz down to bit 0 = 32 Hz. Channel 0 reads at address 1 and channel 1 reads at address 2, in bits [3:0]. A capture on one channel leaves the other channel's register unchanged.
- R5: If a pin change is present before clock edge k, and `samp_tick` is high, the capture register and the done flag update at edge k+2. Neither updates earlier.
- R6: Edges are judged only on cycles where `samp_tick` is high. An edge that arrives while the strobe is low waits, and is captured at the first edge where the strobe is high.
- R7: Each qualifying transition causes exactly one capture. While the pin holds its level, later tap changes do not reach the register.
- R8: While a channel is disabled, its capture register holds and its flag is not raised. A transition seen while disabled is not captured when the channel is enabled later.
- R9: A done flag is cleared by writing 1 to its bit, and writing 0 to it has no effect. If a capture and a clearing write occur in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while some channel has both its enable bit and its done flag set. Clearing the enable bit masks the request but keeps the flag.
- R11: Control register map (address 0):
  - bits [1:0]: enable for channels 1 and 0.
  - bits [3:2]: bias for channels 1 and 0.
  - bits [5:4]: done flags for channels 1 and 0.
  - Unused bits read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | Sampling strobe from the time base |
| tb_taps | input | 4 | Time base taps, bit 3 = 256 Hz, bit 0 = 32 Hz |
| trig_pin | input | 2 | Asynchronous trigger pins, bit n for channel n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 6 | Register write data |
| bus_rdata | output | 6 | Register read data, combinational from address |
| irq | output | 1 | Capture interrupt request |

## Verification
The bound checker checks the following on every cycle:
- A disabled channel's register stays frozen.
- Nothing is captured and no flag rises while the sampling strobe is low.
- Every change of a capture register comes with a set done flag.
- A clearing write with no competing capture clears the flag.
- `irq` is never raised without a flag.

Some properties need chosen stimulus, so only the directed scenarios can show them:
- The polarity choice per bias setting.
- The exact two-cycle synchronizer latency.
- That a held level gives a single capture.
- That set wins over clear in a collision.
- The register map.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  localparam int unsigned NCH_DEF  = 2;
  localparam int unsigned TAPW_DEF = 4;

  // bias encoding held in the control register
  typedef enum logic {
    BIAS_PULLDOWN = 1'b0,
    BIAS_PULLUP   = 1'b1
  } bias_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tbcap_sync.sv
module tbcap_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/tbcap_edge.sv
module tbcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic pin_s,
  input  logic bias_up,
  output logic hit
);
  logic lvl_q;
  logic rise;
  logic fall;

  // level seen at the previous sampling strobe; tracks even when disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lvl_q <= 1'b0;
    else if (samp_tick) lvl_q <= pin_s;
  end

  always_comb begin
    rise = pin_s & ~lvl_q;
    fall = ~pin_s & lvl_q;
    hit  = samp_tick & (bias_up ? fall : rise);
  end
endmodule

// File: rtl/tbcap_capreg.sv
module tbcap_capreg #(
  parameter int unsigned TAPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TAPW-1:0] taps,
  output logic [TAPW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= taps;
  end
endmodule

// File: rtl/tbcap_ctrl.sv
module tbcap_ctrl #(
  parameter int unsigned NCH = 2,
  localparam int unsigned CW = 3 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic [CW-1:0]  wdata,
  input  logic [NCH-1:0] set_done,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] bias_q,
  output logic [NCH-1:0] done_q,
  output logic           irq
);
  localparam int unsigned EN_LO   = 0;
  localparam int unsigned BIAS_LO = NCH;
  localparam int unsigned DONE_LO = 2 * NCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      bias_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wdata[EN_LO +: NCH];
      bias_q <= wdata[BIAS_LO +: NCH];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          done_q[c] <= 1'b0;
      else if (set_done[c])                done_q[c] <= 1'b1;
      else if (wr_ctrl && wdata[DONE_LO+c]) done_q[c] <= 1'b0;
    end
  end

  assign irq = |(done_q & en_q);
endmodule

// File: rtl/tbcap_unit.sv
module tbcap_unit
  import tbcap_pkg::*;
#(
  parameter int unsigned NCH  = NCH_DEF,
  parameter int unsigned TAPW = TAPW_DEF,
  localparam int unsigned CW  = 3 * NCH,
  localparam int unsigned DW  = max2(CW, TAPW),
  localparam int unsigned AW  = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_tick,
  input  logic [TAPW-1:0] tb_taps,
  input  logic [NCH-1:0]  trig_pin,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq
);
  logic [NCH-1:0]           pin_s;
  logic [NCH-1:0]           hit;
  logic [NCH-1:0]           en_q;
  logic [NCH-1:0]           bias_q;
  logic [NCH-1:0]           done_q;
  logic [NCH-1:0][TAPW-1:0] cap_q;
  logic                     wr_ctrl;

  assign wr_ctrl = bus_wr && (bus_addr == '0);

  tbcap_sync #(.W(NCH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_pin),
    .sync_out (pin_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tbcap_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_tick (samp_tick),
      .pin_s     (pin_s[c]),
      .bias_up   (bias_q[c] == BIAS_PULLUP),
      .hit       (hit[c])
    );

    tbcap_capreg #(.TAPW(TAPW)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hit[c] & en_q[c]),
      .taps  (tb_taps),
      .value (cap_q[c])
    );
  end

  tbcap_ctrl #(.NCH(NCH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata[CW-1:0]),
    .set_done (hit & en_q),
    .en_q     (en_q),
    .bias_q   (bias_q),
    .done_q   (done_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata[CW-1:0] = {done_q, bias_q, en_q};
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(bus_addr) == c + 1) bus_rdata[TAPW-1:0] = cap_q[c];
      end
    end
  end
endmodule

// File: rtl/tbcap_chk.sv
module tbcap_chk #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned TAPW = 4,
  parameter int unsigned DW   = 6,
  parameter int unsigned AW   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     samp_tick,
  input logic                     bus_wr,
  input logic [AW-1:0]            bus_addr,
  input logic [DW-1:0]            bus_wdata,
  input logic [NCH-1:0]           hit,
  input logic [NCH-1:0]           en_q,
  input logic [NCH-1:0]           done_q,
  input logic [NCH-1:0][TAPW-1:0] cap_q,
  input logic                     irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |=> $stable(cap_q[c]));

    p_tick_gates_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_tick |=> ($stable(cap_q[c]) && !$rose(done_q[c])));

    p_cap_raises_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_q[c]) |-> done_q[c]);

    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && bus_wdata[2*NCH+c] && !(hit[c] && en_q[c]))
        |=> !done_q[c]);
  end

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_q != '0));
endmodule

bind tbcap_unit tbcap_chk #(.NCH(NCH), .TAPW(TAPW), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .samp_tick (samp_tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .hit       (hit),
  .en_q      (en_q),
  .done_q    (done_q),
  .cap_q     (cap_q),
  .irq       (irq)
);

// File: tb/test_tbcap_unit.sv
module test_tbcap_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b1;
  logic [3:0] tb_taps = '0;
  logic [1:0] trig_pin = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [5:0] bus_wdata = '0;
  logic [5:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbcap_unit i_tbcap_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .tb_taps   (tb_taps),
    .trig_pin  (trig_pin),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input int exp);
    logic [5:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 2'd0, 0);
    rdchk("R1 cap0", 2'd1, 0);
    rdchk("R1 cap1", 2'd2, 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_map;
    wr(2'd0, 6'h0F);
    rdchk("R11 ctrl rw", 2'd0, 'h0F);
    wr(2'd0, 6'h3F);
    rdchk("R11 ctrl no flag set by write", 2'd0, 'h0F);
    rdchk("R11 addr3 zero", 2'd3, 0);
  endtask

  task automatic t_pullup;
    wr(2'd0, 6'h05);
    tb_taps = 4'h5; trig_pin[0] = 1'b1; step(4);
    rdchk("R2 rising ignored", 2'd1, 0);
    rdchk("R2 no flag", 2'd0, 'h05);
    tb_taps = 4'hA; trig_pin[0] = 1'b0; step(2);
    rdchk("R5 not before k+2", 2'd1, 0);
    step(1);
    rdchk("R2 R4 falling captured", 2'd1, 'hA);
    rdchk("R5 flag at k+2", 2'd0, 'h15);
    chk("R10 irq on flag", int'(irq), 1);
    tb_taps = 4'h3; step(5);
    rdchk("R7 single capture", 2'd1, 'hA);
    wr(2'd0, 6'h05);
    rdchk("R9 write0 keeps flag", 2'd0, 'h15);
    wr(2'd0, 6'h15);
    rdchk("R9 w1c clears", 2'd0, 'h05);
    chk("R10 irq drops", int'(irq), 0);
  endtask

  task automatic t_pulldown;
    wr(2'd0, 6'h02);
    tb_taps = 4'h6; trig_pin[1] = 1'b1; step(3);
    rdchk("R3 rising captured ch1", 2'd2, 'h6);
    rdchk("R4 ch0 untouched", 2'd1, 'hA);
    rdchk("R3 flag ch1", 2'd0, 'h22);
    tb_taps = 4'h9; trig_pin[1] = 1'b0; step(4);
    rdchk("R3 falling ignored", 2'd2, 'h6);
    wr(2'd0, 6'h22);
    rdchk("R9 clear ch1", 2'd0, 'h02);
  endtask

  task automatic t_disable;
    wr(2'd0, 6'h00);
    tb_taps = 4'hF; trig_pin[1] = 1'b1; step(5);
    rdchk("R8 disabled holds", 2'd2, 'h6);
    rdchk("R8 no flag", 2'd0, 0);
    chk("R8 no irq", int'(irq), 0);
    wr(2'd0, 6'h02); step(4);
    rdchk("R8 no late capture", 2'd2, 'h6);
    rdchk("R8 flag stays clear", 2'd0, 'h02);
  endtask

  task automatic t_tick;
    trig_pin[1] = 1'b0; step(4);
    rdchk("R3 falling ignored again", 2'd2, 'h6);
    samp_tick = 1'b0; tb_taps = 4'hC; trig_pin[1] = 1'b1; step(6);
    rdchk("R6 waits for strobe", 2'd2, 'h6);
    rdchk("R6 no flag without strobe", 2'd0, 'h02);
    samp_tick = 1'b1; step(1);
    rdchk("R6 captured on strobe", 2'd2, 'hC);
  endtask

  task automatic t_irq_mask;
    chk("R10 irq set", int'(irq), 1);
    wr(2'd0, 6'h00);
    rdchk("R10 flag kept when masked", 2'd0, 'h20);
    chk("R10 irq masked", int'(irq), 0);
    wr(2'd0, 6'h02);
    chk("R10 irq unmasked", int'(irq), 1);
    wr(2'd0, 6'h22);
    chk("R10 irq cleared", int'(irq), 0);
  endtask

  task automatic t_set_wins;
    wr(2'd0, 6'h01);
    tb_taps = 4'h7; trig_pin[0] = 1'b1; step(2);
    wr(2'd0, 6'h11);
    rdchk("R9 set beats clear", 2'd0, 'h11);
    rdchk("R4 ch0 value", 2'd1, 'h7);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_pullup();
    t_pulldown();
    t_disable();
    t_tick();
    t_irq_mask();
    t_set_wins();
    step(2);
    finish_run();
  end
endmodule